// File: doc/BRIEF.md
# Sensor Threshold Alarm Classifier

The classifier takes in a stream of sampled sensor readings. Each reading is an unsigned 12-bit code tagged with a slot index. Every slot is configured either as a voltage rail or as a temperature channel. The reading is compared against that slot's four limit registers, and each limit has its own enable bit.

On a voltage slot the four limits form two nested windows. The inner window raises a critical warning. The outer window requests a payload shutdown. On a temperature slot the four limits are rising levels: minor, major, critical and emergency. The block keeps the current severity for every slot. It emits a one-cycle event carrying the slot index and the new severity whenever a slot's severity changes. It also holds a sticky shutdown request until that request is cleared by a write.

Limits and slot modes are loaded through a small write-only register port. Management firmware typically programs the limits once. A sampling engine then feeds readings in round-robin order, and the firmware watches the event stream and the shutdown line.

Top module: `sens_alarm_top`

## Requirements
- R1: After reset, every slot's severity is NONE (code 0), no event is flagged, the shutdown request is low, and every limit register, enable bit and mode bit is zero.
- R2: On a voltage slot (mode bit 0), a reading strictly below enabled limit 0 or strictly above enabled limit 1 gives severity CRIT (code 3). A reading inside that window, or equal to either limit, gives severity NONE (code 0).
- R3: On a voltage slot, a reading strictly below enabled limit 2 or strictly above enabled limit 3 sets the shutdown request and gives severity CRIT.
- R4: A limit whose enable bit is 0 never contributes to severity or to the shutdown request, whatever its value.
- R5: On a temperature slot (mode bit 1), the severity is that of the highest-ranked enabled level the reading strictly exceeds. Limit 2 ranks highest and gives CRIT (3). Limit 1 gives MAJOR (2). Limit 0 gives MINOR (1). A reading equal to a limit does not reach that level.
- R6: On a temperature slot, a reading strictly above enabled limit 3 sets the shutdown request and forces severity CRIT. With limit 3 equal to limit 2, the critical alarm and the shutdown request are raised by the same reading.
- R7: One cycle after a valid sample whose severity differs from the slot's stored severity, evt_valid is high for one cycle, with evt_idx set to the slot and evt_sev set to the new severity. Otherwise evt_valid stays low.
- R8: A sample updates only the stored severity of its own slot, and each slot's severity stays unchanged until a new sample for that slot arrives.
- R9: The shutdown request is sticky. A register write to field 7 (any slot) clears it one cycle later. A tripping sample in the same cycle as such a write wins, and the request stays set.
- R10: The register address is {slot, field[2:0]}. Fields 0 to 3 load limits 0 to 3 from wdata[11:0]. Field 4 loads the enable bits from wdata[3:0] (bit i enables limit i) and the mode bit from wdata[4]. A write is applied at the clock edge, so a sample presented in the same cycle is still classified with the old settings.
- R11: The stored severities, the event outputs and the shutdown request all change at the clock edge that captures the sample, one cycle after the sample is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Write address: slot in bits 6:3, field in bits 2:0 |
| cfg_wdata | input | 12 | Write data |
| smp_valid | input | 1 | Reading present this cycle |
| smp_idx | input | 4 | Slot index of the reading |
| smp_code | input | 12 | Unsigned reading code |
| evt_valid | output | 1 | Severity change event strobe |
| evt_idx | output | 4 | Slot whose severity changed |
| evt_sev | output | 2 | New severity (0 NONE, 1 MINOR, 2 MAJOR, 3 CRIT) |
| sev_status | output | 32 | Stored severity per slot, slot s in bits 2s+1:2s |
| shut_req | output | 1 | Sticky payload shutdown request |

## Verification
On a voltage rail, readings are placed exactly on each window edge and one code beyond it. This separates strict comparisons from inclusive ones, and separates the inner window from the outer one. Temperature readings are stepped up through the three alarm levels and onto each threshold, which shows both the ranking of the levels and the strict greater-than rule. A rail with most limits disabled, but with limit values that would otherwise fire, shows that a disabled limit is truly ignored. Repeated identical readings, interleaved slots, a clear colliding with a trip, and a write colliding with a sample cover event suppression, per-slot isolation and ordering at the edge. A long random mix of writes and readings is then compared against a behavioural model on every clock.

// File: rtl/sa_pkg.sv
package sa_pkg;

    localparam int unsigned CODE_W  = 12;
    localparam int unsigned NLIM    = 4;
    localparam int unsigned FIELD_W = 3;

    localparam logic [FIELD_W-1:0] FLD_CTRL  = 3'd4;
    localparam logic [FIELD_W-1:0] FLD_CLEAR = 3'd7;

    typedef enum logic [1:0] {
        SEV_NONE  = 2'd0,
        SEV_MINOR = 2'd1,
        SEV_MAJOR = 2'd2,
        SEV_CRIT  = 2'd3
    } sev_e;

    typedef enum logic {
        KIND_VOLT = 1'b0,
        KIND_TEMP = 1'b1
    } kind_e;

    typedef struct packed {
        kind_e                       kind;
        logic [NLIM-1:0]             en;
        logic [NLIM-1:0][CODE_W-1:0] lim;
    } slot_cfg_t;

    typedef struct packed {
        sev_e sev;
        logic trip;
    } verdict_t;

    function automatic sev_e temp_rank(input logic gt_min, input logic gt_maj,
                                       input logic gt_crit);
        if (gt_crit)     return SEV_CRIT;
        else if (gt_maj) return SEV_MAJOR;
        else if (gt_min) return SEV_MINOR;
        else             return SEV_NONE;
    endfunction

endpackage

// File: rtl/sa_cfg_bank.sv
module sa_cfg_bank
    import sa_pkg::*;
#(
    parameter int unsigned SENS_N = 16,
    localparam int unsigned IDX_W = $clog2(SENS_N),
    localparam int unsigned ADR_W = IDX_W + FIELD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADR_W-1:0]  addr,
    input  logic [CODE_W-1:0] wdata,
    output slot_cfg_t         cfg_o [SENS_N],
    output logic              clr_o
);

    logic [IDX_W-1:0]   wr_slot;
    logic [FIELD_W-1:0] wr_field;
    slot_cfg_t          cfg_q [SENS_N];

    assign wr_slot  = addr[ADR_W-1:FIELD_W];
    assign wr_field = addr[FIELD_W-1:0];
    assign clr_o    = we && (wr_field == FLD_CLEAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SENS_N; s++) cfg_q[s] <= '0;
        end else if (we) begin
            for (int s = 0; s < SENS_N; s++) begin
                if (wr_slot == IDX_W'(s)) begin
                    if (wr_field < FIELD_W'(NLIM)) begin
                        cfg_q[s].lim[wr_field[1:0]] <= wdata;
                    end else if (wr_field == FLD_CTRL) begin
                        cfg_q[s].en   <= wdata[NLIM-1:0];
                        cfg_q[s].kind <= kind_e'(wdata[NLIM]);
                    end
                end
            end
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/sa_level_eval.sv
module sa_level_eval
    import sa_pkg::*;
(
    input  slot_cfg_t         cfg,
    input  logic [CODE_W-1:0] code,
    output verdict_t          verdict
);

    logic [NLIM-1:0] above;
    logic            below_warn;
    logic            below_shut;
    logic            volt_warn;
    logic            volt_trip;
    logic            temp_trip;

    for (genvar i = 0; i < NLIM; i++) begin : g_above
        assign above[i] = cfg.en[i] && (code > cfg.lim[i]);
    end

    assign below_warn = cfg.en[0] && (code < cfg.lim[0]);
    assign below_shut = cfg.en[2] && (code < cfg.lim[2]);
    assign volt_warn  = below_warn || above[1];
    assign volt_trip  = below_shut || above[3];
    assign temp_trip  = above[3];

    always_comb begin
        if (cfg.kind == KIND_VOLT) begin
            verdict.trip = volt_trip;
            verdict.sev  = (volt_warn || volt_trip) ? SEV_CRIT : SEV_NONE;
        end else begin
            verdict.trip = temp_trip;
            verdict.sev  = temp_trip ? SEV_CRIT
                                     : temp_rank(above[0], above[1], above[2]);
        end
    end

endmodule

// File: rtl/sa_status_track.sv
module sa_status_track
    import sa_pkg::*;
#(
    parameter int unsigned SENS_N = 16,
    localparam int unsigned IDX_W = $clog2(SENS_N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IDX_W-1:0] in_idx,
    input  verdict_t         in_verdict,
    input  logic             clr,
    output sev_e             sev_q [SENS_N],
    output logic             evt_valid,
    output logic [IDX_W-1:0] evt_idx,
    output sev_e             evt_sev,
    output logic             shut_req
);

    logic in_range;
    logic trip_now;

    assign in_range = (32'(in_idx) < SENS_N);
    assign trip_now = in_valid && in_range && in_verdict.trip;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SENS_N; s++) sev_q[s] <= SEV_NONE;
            evt_valid <= 1'b0;
            evt_idx   <= '0;
            evt_sev   <= SEV_NONE;
        end else begin
            evt_valid <= 1'b0;
            if (in_valid && in_range && (in_verdict.sev != sev_q[in_idx])) begin
                sev_q[in_idx] <= in_verdict.sev;
                evt_valid     <= 1'b1;
                evt_idx       <= in_idx;
                evt_sev       <= in_verdict.sev;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           shut_req <= 1'b0;
        else if (trip_now) shut_req <= 1'b1;
        else if (clr)      shut_req <= 1'b0;
    end

    a_r7_evt_needs_sample: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> $past(in_valid));

    a_r7_evt_matches_state: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> (sev_q[evt_idx] == evt_sev));

    a_r9_shut_sticky: assert property (@(posedge clk) disable iff (rst)
        (shut_req && !clr) |=> shut_req);

    a_r9_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr && !trip_now) |=> !shut_req);

    a_r3_trip_sets_shut: assert property (@(posedge clk) disable iff (rst)
        trip_now |=> shut_req);

    a_r6_trip_is_crit: assert property (@(posedge clk) disable iff (rst)
        trip_now |=> (sev_q[$past(in_idx)] == SEV_CRIT));

endmodule

// File: rtl/sens_alarm_top.sv
module sens_alarm_top
    import sa_pkg::*;
#(
    parameter int unsigned SENS_N = 16,
    localparam int unsigned IDX_W = $clog2(SENS_N),
    localparam int unsigned ADR_W = IDX_W + FIELD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [ADR_W-1:0]    cfg_addr,
    input  logic [CODE_W-1:0]   cfg_wdata,
    input  logic                smp_valid,
    input  logic [IDX_W-1:0]    smp_idx,
    input  logic [CODE_W-1:0]   smp_code,
    output logic                evt_valid,
    output logic [IDX_W-1:0]    evt_idx,
    output logic [1:0]          evt_sev,
    output logic [2*SENS_N-1:0] sev_status,
    output logic                shut_req
);

    slot_cfg_t cfg_arr [SENS_N];
    slot_cfg_t sel_cfg;
    verdict_t  verdict;
    sev_e      sev_arr [SENS_N];
    sev_e      evt_sev_e;
    logic      clr;

    sa_cfg_bank #(.SENS_N(SENS_N)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg_o (cfg_arr),
        .clr_o (clr)
    );

    always_comb begin
        sel_cfg = '0;
        for (int s = 0; s < SENS_N; s++) begin
            if (smp_idx == IDX_W'(s)) sel_cfg = cfg_arr[s];
        end
    end

    sa_level_eval u_eval (
        .cfg     (sel_cfg),
        .code    (smp_code),
        .verdict (verdict)
    );

    sa_status_track #(.SENS_N(SENS_N)) u_track (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (smp_valid),
        .in_idx     (smp_idx),
        .in_verdict (verdict),
        .clr        (clr),
        .sev_q      (sev_arr),
        .evt_valid  (evt_valid),
        .evt_idx    (evt_idx),
        .evt_sev    (evt_sev_e),
        .shut_req   (shut_req)
    );

    assign evt_sev = evt_sev_e;

    for (genvar s = 0; s < SENS_N; s++) begin : g_flat
        assign sev_status[2*s +: 2] = sev_arr[s];
    end

endmodule

// File: tb/sens_alarm_top_tb.sv
module sens_alarm_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [11:0] cfg_wdata = '0;
    logic        smp_valid = 1'b0;
    logic [3:0]  smp_idx = '0;
    logic [11:0] smp_code = '0;
    logic        evt_valid;
    logic [3:0]  evt_idx;
    logic [1:0]  evt_sev;
    logic [31:0] sev_status;
    logic        shut_req;

    always #2.5 clk = ~clk;

    sens_alarm_top u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .smp_valid(smp_valid), .smp_idx(smp_idx),
        .smp_code(smp_code), .evt_valid(evt_valid), .evt_idx(evt_idx),
        .evt_sev(evt_sev), .sev_status(sev_status), .shut_req(shut_req)
    );

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R1";
    bit done = 0;

    // behavioural reference state
    int m_lim [16][4];
    int m_en [16];
    int m_kind [16];
    int m_sev [16];
    bit m_shut;
    bit m_ev;
    int m_ev_idx;
    int m_ev_sev;

    task automatic check(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic void mclass(input int s, input int c, output int sev, output bit trip);
        bit w;
        if (m_kind[s] == 0) begin
            w    = (m_en[s][0] && c < m_lim[s][0]) || (m_en[s][1] && c > m_lim[s][1]);
            trip = (m_en[s][2] && c < m_lim[s][2]) || (m_en[s][3] && c > m_lim[s][3]);
            sev  = (w || trip) ? 3 : 0;
        end else begin
            sev = 0;
            if (m_en[s][0] && c > m_lim[s][0]) sev = 1;
            if (m_en[s][1] && c > m_lim[s][1]) sev = 2;
            if (m_en[s][2] && c > m_lim[s][2]) sev = 3;
            trip = m_en[s][3] && c > m_lim[s][3];
            if (trip) sev = 3;
        end
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < 16; s++) begin
                m_en[s] = 0; m_kind[s] = 0; m_sev[s] = 0;
                for (int l = 0; l < 4; l++) m_lim[s][l] = 0;
            end
            m_shut = 0; m_ev = 0; m_ev_idx = 0; m_ev_sev = 0;
        end else begin
            int  sv;
            bit  tr;
            tr = 0;
            m_ev = 0;
            if (smp_valid) begin
                mclass(int'(smp_idx), int'(smp_code), sv, tr);
                if (sv != m_sev[smp_idx]) begin
                    m_sev[smp_idx] = sv;
                    m_ev = 1; m_ev_idx = int'(smp_idx); m_ev_sev = sv;
                end
            end
            if (smp_valid && tr) m_shut = 1;
            else if (cfg_we && cfg_addr[2:0] == 3'd7) m_shut = 0;
            if (cfg_we) begin
                if (cfg_addr[2:0] < 3'd4) m_lim[cfg_addr[6:3]][cfg_addr[1:0]] = int'(cfg_wdata);
                else if (cfg_addr[2:0] == 3'd4) begin
                    m_en[cfg_addr[6:3]]   = int'(cfg_wdata[3:0]);
                    m_kind[cfg_addr[6:3]] = int'(cfg_wdata[4]);
                end
            end
        end
    end

    // cycle-by-cycle comparison against the model (R11 timing)
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(cur_req, int'(evt_valid), int'(m_ev), "evt_valid");
            if (m_ev) begin
                check(cur_req, int'(evt_idx), m_ev_idx, "evt_idx");
                check(cur_req, int'(evt_sev), m_ev_sev, "evt_sev");
            end
            check(cur_req, int'(shut_req), int'(m_shut), "shut_req");
            for (int s = 0; s < 16; s++)
                check(cur_req, int'(sev_status[2*s +: 2]), m_sev[s], "sev_status");
        end
    end

    task automatic wr(input int s, input int f, input int d);
        cfg_we = 1; cfg_addr = {s[3:0], f[2:0]}; cfg_wdata = d[11:0];
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic smp(input int i, input int c);
        smp_valid = 1; smp_idx = i[3:0]; smp_code = c[11:0];
        @(negedge clk);
        smp_valid = 0;
    endtask

    task automatic slot_setup(input int s, input int l0, input int l1, input int l2,
                              input int l3, input int ctrl);
        wr(s, 0, l0); wr(s, 1, l1); wr(s, 2, l2); wr(s, 3, l3); wr(s, 4, ctrl);
    endtask

    task automatic sev_is(input string req, input int s, input int exp);
        check(req, int'(sev_status[2*s +: 2]), exp, "slot severity");
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        cur_req = "R1";
        check("R1", int'(sev_status), 0, "reset status");
        check("R1", int'(shut_req), 0, "reset shut");
        check("R1", int'(evt_valid), 0, "reset evt");
        // R1: limits reset to zero: voltage slot with nothing enabled stays NONE
        smp(9, 4095);
        sev_is("R1", 9, 0);

        // R2/R3 voltage windows on slot 0
        cur_req = "R10";
        slot_setup(0, 1860, 2140, 1800, 2200, 'h0F);
        cur_req = "R2";
        smp(0, 2000);  sev_is("R2", 0, 0); check("R7", int'(evt_valid), 0, "no change no event");
        smp(0, 1860);  sev_is("R2", 0, 0);
        smp(0, 2140);  sev_is("R2", 0, 0);
        smp(0, 1859);  sev_is("R2", 0, 3); check("R7", int'(evt_valid), 1, "event on change");
        check("R7", int'(evt_idx), 0, "event idx");
        smp(0, 2141);  sev_is("R2", 0, 3); check("R7", int'(evt_valid), 0, "same sev no event");
        check("R2", int'(shut_req), 0, "warn only no shut");
        smp(0, 2000);  check("R7", int'(evt_sev), 0, "event back to none");
        cur_req = "R3";
        smp(0, 1800);  check("R3", int'(shut_req), 0, "edge of outer window");
        smp(0, 2201);  check("R3", int'(shut_req), 1, "outer trip");  sev_is("R3", 0, 3);
        smp(0, 2000);  check("R9", int'(shut_req), 1, "sticky");
        cur_req = "R9";
        wr(5, 7, 0);   check("R9", int'(shut_req), 0, "cleared");
        smp(0, 1799);  check("R3", int'(shut_req), 1, "low trip");

        // R9: trip and clear in the same cycle, set wins
        cfg_we = 1; cfg_addr = {4'd0, 3'd7}; smp_valid = 1; smp_idx = 0; smp_code = 12'd2300;
        @(negedge clk);
        cfg_we = 0; smp_valid = 0;
        check("R9", int'(shut_req), 1, "set beats clear");
        wr(0, 7, 0);

        // R4: battery-like rail, only lower warn enabled; others would fire
        cur_req = "R4";
        slot_setup(1, 1500, 0, 4000, 0, 'h01);
        smp(1, 3000);  sev_is("R4", 1, 0); check("R4", int'(shut_req), 0, "disabled shut");
        smp(1, 100);   sev_is("R4", 1, 3); check("R4", int'(shut_req), 0, "disabled low shut");

        // R5/R6 processor diode temperature
        cur_req = "R5";
        slot_setup(4, 80, 90, 102, 102, 'h1F);
        smp(4, 80);   sev_is("R5", 4, 0);
        smp(4, 81);   sev_is("R5", 4, 1);
        smp(4, 90);   sev_is("R5", 4, 1);
        smp(4, 91);   sev_is("R5", 4, 2);
        smp(4, 102);  sev_is("R5", 4, 2); check("R6", int'(shut_req), 0, "equal no emerg");
        cur_req = "R6";
        smp(4, 103);  sev_is("R6", 4, 3); check("R6", int'(shut_req), 1, "emerg with crit");
        wr(0, 7, 0);

        // R8 board sensor, other slots untouched
        cur_req = "R8";
        slot_setup(6, 60, 70, 88, 88, 'h17);
        smp(6, 75);   sev_is("R8", 6, 2); sev_is("R8", 4, 3); sev_is("R8", 0, 3);
        smp(6, 89);   sev_is("R5", 6, 3); check("R4", int'(shut_req), 0, "emerg disabled");

        // R10: write and sample in the same cycle use the old config
        cur_req = "R10";
        cfg_we = 1; cfg_addr = {4'd6, 3'd2}; cfg_wdata = 12'd200;
        smp_valid = 1; smp_idx = 6; smp_code = 12'd50;
        @(negedge clk);
        cfg_we = 0; smp_valid = 0;
        sev_is("R10", 6, 0);
        smp(6, 150);  sev_is("R10", 6, 2);

        // random mix, model compared every clock
        cur_req = "R11";
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 2) begin
                int f;
                f = $urandom_range(0, 5);
                if (f == 5) f = 7;
                wr($urandom_range(0, 15), f, $urandom_range(0, 4095));
            end else if (r < 9) begin
                smp($urandom_range(0, 15), $urandom_range(0, 4095));
            end else begin
                @(negedge clk);
            end
        end
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule